// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers interrupt events from six groups of status inputs in a line-interface device and reduces them to one active-low interrupt pin. Each status input feeds a latched first-level bit. Most inputs are single-event sources, which latch only when the status rises. A few are dual-event sources, which latch on a rise and again on a fall, so that both the loss and the recovery of a condition are reported. Software reads a first-level register to collect its pending bits, and the read clears them.

Each first-level bit has its own enable. The enabled bits of a group are ORed into one bit of a summary register. The summary register also holds a latched one-second tick indication. A summary enable mask and a global pin enable in the general control register select what reaches the pin. Software uses a simple address/data port: it writes the enables and reads the interrupt registers. Read data comes back one cycle after the read strobe.

Top module: `irq_agg_ctrl`

## Requirements
- R1: A single-event bit sets on the first clock edge after its status input goes from 0 to 1. A fall of that input never sets it. Default single-event sources are every bit except those listed in R2.
- R2: A dual-event bit sets on the first clock edge after its status input changes in either direction. The default dual-event sources are receive-cell register bit 7 (cell delineation lost or regained) and protection-switch register bits 3..0.
- R3: The interrupt registers are read-only: section 0x3C, line 0x3D, path 0x3E, protection 0x3F, transmit-cell 0x40 (bit 7 is transmit bus parity error) and receive-cell 0x41. A read with bus_rd returns the register on bus_rdata after the next clock edge and clears every bit of that register that has no new event.
- R4: If an event reaches a bit in the same cycle as a clearing read of its register, the read returns the old value and the bit stays set afterwards.
- R5: Each interrupt register has a read/write enable register at its address plus 0x10 (0x4C..0x51), and these reset to 0. A bit whose enable is 0 adds nothing to the summary.
- R6: The summary register at 0x42 is read-only. Bit g is the OR of the enabled bits of group g, in the order section 0, line 1, path 2, protection 3, transmit-cell 4, receive-cell 5. Bit 7 reads 0. Reading it leaves the group bits unchanged.
- R7: A one-cycle pulse on tick_1s latches summary bit 6. A read of 0x42 clears it, unless a tick arrives in the same cycle as the read.
- R8: irq_n is low only when bit 6 of the general register (0x00) is set and the summary register ANDed with the summary enable register (0x52) is nonzero. Both registers are read/write.
- R9: After reset, all latched bits and all enable and control registers read 0, bus_rdata is 0 and irq_n is high.
- R10: Writes to the interrupt registers or the summary register have no effect, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; clears the interrupt register it reads |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| stat_in | input | 48 | Status inputs, group g at bits 8g+7..8g |
| tick_1s | input | 1 | One-cycle pulse from the one-second timer |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The bench sweeps every status bit of every group. For each bit it checks that the bit latches on a rise, that the read clears it, and that a fall latches it again only on the dual-event positions. A design that ignored falls would miss the recovery report, and one that latched every fall would flood software with spurious interrupts. A status rise timed to land on the clearing read targets the lost-event race: a naive clear-wins design would drop that event for good. The bench also masks single bits, the summary and the global pin enable to expose a pin that fires while masked. It checks that the tick bit survives a same-cycle read, and that writes to read-only registers leave pending bits intact.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_GRP    = 6;
    localparam int ADDR_W     = 8;
    localparam int GIDX_W     = $clog2(NUM_GRP);
    localparam int PIN_EN_BIT = 6;
    localparam int TICK_BIT   = NUM_GRP;

    localparam logic [ADDR_W-1:0] GEN_ADDR   = 8'h00;
    localparam logic [ADDR_W-1:0] INT_BASE   = 8'h3C;
    localparam logic [ADDR_W-1:0] SUM_ADDR   = 8'h42;
    localparam logic [ADDR_W-1:0] EN_OFS     = 8'h10;
    localparam logic [ADDR_W-1:0] SUMEN_ADDR = 8'h52;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GEN,
        SEL_INT,
        SEL_EN,
        SEL_SUM,
        SEL_SUMEN
    } sel_e;

    typedef struct packed {
        sel_e              sel;
        logic [GIDX_W-1:0] grp;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.sel = SEL_NONE;
        d.grp = '0;
        if (a == GEN_ADDR)   d.sel = SEL_GEN;
        if (a == SUM_ADDR)   d.sel = SEL_SUM;
        if (a == SUMEN_ADDR) d.sel = SEL_SUMEN;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (a == INT_BASE + ADDR_W'(g)) begin
                d.sel = SEL_INT;
                d.grp = GIDX_W'(g);
            end
            if (a == INT_BASE + EN_OFS + ADDR_W'(g)) begin
                d.sel = SEL_EN;
                d.grp = GIDX_W'(g);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   DUAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stat,
    input  logic         clr,
    output logic [W-1:0] q
);

    logic [W-1:0] stat_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] evt;

    always_comb begin
        rise = stat & ~stat_q;
        fall = ~stat & stat_q;
        evt  = rise | (fall & DUAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            q      <= '0;
        end else begin
            stat_q <= stat;
            q      <= (q & ~{W{clr}}) | evt;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit_chk
        // R1
        rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
            (stat[i] && !stat_q[i]) |=> q[i]);
        // R3
        read_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (clr && (stat[i] == stat_q[i])) |=> !q[i]);
        if (DUAL[i]) begin : g_dual
            // R2
            fall_sets_chk: assert property (@(posedge clk) disable iff (rst)
                (!stat[i] && stat_q[i]) |=> q[i]);
        end else begin : g_single
            // R1
            fall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
                (!stat[i] && stat_q[i] && !q[i]) |=> !q[i]);
        end
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int GRP_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            wr,
    input  logic                            rd,
    input  logic [GRP_W-1:0]                wdata,
    input  logic [NUM_GRP-1:0][GRP_W-1:0]   int_bits,
    input  logic [GRP_W-1:0]                sum_val,
    output logic [NUM_GRP-1:0][GRP_W-1:0]   en,
    output logic [GRP_W-1:0]                sum_en,
    output logic [GRP_W-1:0]                gen,
    output logic [NUM_GRP-1:0]              int_clr,
    output logic                            sum_clr,
    output logic [GRP_W-1:0]                rdata
);

    dec_t             dec;
    logic [GRP_W-1:0] rd_mux;

    assign dec = decode(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            gen    <= '0;
            sum_en <= '0;
            en     <= '0;
        end else if (wr) begin
            if (dec.sel == SEL_GEN)   gen    <= wdata;
            if (dec.sel == SEL_SUMEN) sum_en <= wdata;
            for (int g = 0; g < NUM_GRP; g++) begin
                if (dec.sel == SEL_EN && dec.grp == GIDX_W'(g)) en[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (dec.sel)
            SEL_GEN:   rd_mux = gen;
            SEL_SUM:   rd_mux = sum_val;
            SEL_SUMEN: rd_mux = sum_en;
            SEL_INT: begin
                for (int g = 0; g < NUM_GRP; g++)
                    if (dec.grp == GIDX_W'(g)) rd_mux = int_bits[g];
            end
            SEL_EN: begin
                for (int g = 0; g < NUM_GRP; g++)
                    if (dec.grp == GIDX_W'(g)) rd_mux = en[g];
            end
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        for (int g = 0; g < NUM_GRP; g++)
            int_clr[g] = rd && (dec.sel == SEL_INT) && (dec.grp == GIDX_W'(g));
        sum_clr = rd && (dec.sel == SEL_SUM);
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    // R3
    one_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({int_clr, sum_clr}));
    // R3
    clear_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        (|{int_clr, sum_clr}) |-> rd);
    // R10
    no_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_agg_pkg::*;
#(
    parameter int GRP_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_GRP-1:0][GRP_W-1:0] int_bits,
    input  logic [NUM_GRP-1:0][GRP_W-1:0] en,
    input  logic                          sec_flag,
    input  logic [GRP_W-1:0]              sum_en,
    input  logic                          pin_en,
    output logic [GRP_W-1:0]              sum_val,
    output logic                          irq_n
);

    logic [GRP_W-1:0] sum_raw;

    for (genvar g = 0; g < GRP_W; g++) begin : g_sum
        if (g < NUM_GRP) begin : g_grp
            assign sum_raw[g] = |(int_bits[g] & en[g]);
        end else if (g == TICK_BIT) begin : g_tick
            assign sum_raw[g] = sec_flag;
        end else begin : g_zero
            assign sum_raw[g] = 1'b0;
        end
    end

    assign sum_val = sum_raw;
    assign irq_n   = ~(pin_en & |(sum_val & sum_en));

    // R8
    pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_en |-> irq_n);
    // R8
    pin_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (sum_en == '0) |-> irq_n);
    // R5
    all_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0 && !sec_flag) |-> (sum_val == '0));

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int                         GRP_W     = 8,
    parameter logic [NUM_GRP*GRP_W-1:0]   DUAL_MASK = {8'h80, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h00}
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [GRP_W-1:0]          bus_wdata,
    input  logic                      bus_rd,
    output logic [GRP_W-1:0]          bus_rdata,
    input  logic [NUM_GRP*GRP_W-1:0]  stat_in,
    input  logic                      tick_1s,
    output logic                      irq_n
);

    logic [NUM_GRP-1:0][GRP_W-1:0] int_bits;
    logic [NUM_GRP-1:0][GRP_W-1:0] en;
    logic [GRP_W-1:0]              sum_en;
    logic [GRP_W-1:0]              gen;
    logic [GRP_W-1:0]              sum_val;
    logic [NUM_GRP-1:0]            int_clr;
    logic                          sum_clr;
    logic                          sec_flag;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_src
        irq_src_latch #(
            .W    (GRP_W),
            .DUAL (DUAL_MASK[g*GRP_W +: GRP_W])
        ) u_latch (
            .clk  (clk),
            .rst  (rst),
            .stat (stat_in[g*GRP_W +: GRP_W]),
            .clr  (int_clr[g]),
            .q    (int_bits[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) sec_flag <= 1'b0;
        else     sec_flag <= (sec_flag & ~sum_clr) | tick_1s;
    end

    irq_regs #(.GRP_W(GRP_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .int_bits (int_bits),
        .sum_val  (sum_val),
        .en       (en),
        .sum_en   (sum_en),
        .gen      (gen),
        .int_clr  (int_clr),
        .sum_clr  (sum_clr),
        .rdata    (bus_rdata)
    );

    irq_summary #(.GRP_W(GRP_W)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .int_bits (int_bits),
        .en       (en),
        .sec_flag (sec_flag),
        .sum_en   (sum_en),
        .pin_en   (gen[PIN_EN_BIT]),
        .sum_val  (sum_val),
        .irq_n    (irq_n)
    );

    // R7
    tick_latch_chk: assert property (@(posedge clk) disable iff (rst)
        tick_1s |=> sec_flag);
    // R7
    tick_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sum_clr && !tick_1s) |=> !sec_flag);
    // R6
    sum_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        sum_clr |=> (int_bits == $past(int_bits) | int_bits));

endmodule

// File: tb/irq_agg_ctrl_tb.sv
module irq_agg_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic [47:0] stat_in;
    logic        tick_1s;
    logic        irq_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_agg_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .stat_in   (stat_in),
        .tick_1s   (tick_1s),
        .irq_n     (irq_n)
    );

    function automatic bit is_dual(int g, int b);
        return (g == 5 && b == 7) || (g == 3 && b < 4);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0;
        stat_in = '0; tick_1s = 0;
        @(negedge clk); step(); step();
        rst = 1'b0;

        // R9 reset state
        chk("R9 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R9 rdata", bus_rdata, 8'h00);
        rd_reg(8'h00, r); chk("R9 gen", r, 8'h00);
        for (int g = 0; g < 6; g++) begin
            rd_reg(8'h4C + 8'(g), r); chk("R9 enable", r, 8'h00);
            rd_reg(8'h3C + 8'(g), r); chk("R9 int", r, 8'h00);
        end

        // R5 R8 configuration readback
        for (int g = 0; g < 6; g++) wr_reg(8'h4C + 8'(g), 8'hFF);
        wr_reg(8'h52, 8'h7F);
        wr_reg(8'h00, 8'h40);
        rd_reg(8'h4E, r); chk("R5 enable readback", r, 8'hFF);
        rd_reg(8'h52, r); chk("R8 summary enable readback", r, 8'h7F);
        rd_reg(8'h00, r); chk("R8 gen readback", r, 8'h40);

        // R1 R2 R3 R6 sweep over every source bit
        for (int g = 0; g < 6; g++) begin
            for (int b = 0; b < 8; b++) begin
                stat_in[g*8+b] = 1'b1;
                step();
                chk("R8 pin low", {7'd0, irq_n}, 8'h00);
                rd_reg(8'h42, r); chk("R6 summary bit", r, 8'(1 << g));
                rd_reg(8'h3C + 8'(g), r); chk("R1 rise latched", r, 8'(1 << b));
                rd_reg(8'h3C + 8'(g), r); chk("R3 cleared by read", r, 8'h00);
                chk("R8 pin released", {7'd0, irq_n}, 8'h01);
                stat_in[g*8+b] = 1'b0;
                step();
                rd_reg(8'h3C + 8'(g), r);
                if (is_dual(g, b)) chk("R2 fall latched", r, 8'(1 << b));
                else               chk("R1 fall ignored", r, 8'h00);
            end
        end

        // R4 event during clearing read
        stat_in[4*8+7] = 1'b1;
        bus_addr = 8'h40; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
        chk("R4 read returns old", bus_rdata, 8'h00);
        rd_reg(8'h40, r); chk("R4 bit kept", r, 8'h80);
        stat_in[4*8+7] = 1'b0; step();
        stat_in[5*8+7] = 1'b1; step();
        bus_addr = 8'h41; bus_rd = 1'b1; stat_in[5*8+7] = 1'b0;
        step();
        bus_rd = 1'b0;
        chk("R4 dual read old", bus_rdata, 8'h80);
        rd_reg(8'h41, r); chk("R4 dual fall kept", r, 8'h80);

        // R5 disabled bit does not reach summary
        wr_reg(8'h4E, 8'hF7);
        stat_in[2*8+3] = 1'b1; step();
        rd_reg(8'h42, r); chk("R5 masked bit", r, 8'h00);
        chk("R5 pin quiet", {7'd0, irq_n}, 8'h01);
        stat_in[2*8+4] = 1'b1; step();
        rd_reg(8'h42, r); chk("R5 enabled bit", r, 8'h04);
        // R6 summary read leaves group bits
        rd_reg(8'h3E, r); chk("R6 group intact", r, 8'h18);
        stat_in[2*8+3] = 1'b0; stat_in[2*8+4] = 1'b0; step();
        wr_reg(8'h4E, 8'hFF);

        // R8 gating by summary mask and global enable
        stat_in[0] = 1'b1; step();
        wr_reg(8'h52, 8'h7E);
        chk("R8 summary masked", {7'd0, irq_n}, 8'h01);
        wr_reg(8'h52, 8'h01);
        chk("R8 summary enabled", {7'd0, irq_n}, 8'h00);
        wr_reg(8'h00, 8'h00);
        chk("R8 global off", {7'd0, irq_n}, 8'h01);
        wr_reg(8'h00, 8'h40);
        chk("R8 global on", {7'd0, irq_n}, 8'h00);

        // R10 writes to read-only registers ignored
        wr_reg(8'h3C, 8'h00);
        wr_reg(8'h42, 8'hFF);
        rd_reg(8'h42, r); chk("R10 summary unwritten", r, 8'h01);
        rd_reg(8'h3C, r); chk("R10 int unwritten", r, 8'h01);
        stat_in[0] = 1'b0; step();
        wr_reg(8'h40, 8'hFF);
        rd_reg(8'h40, r); chk("R10 int write ignored", r, 8'h00);
        rd_reg(8'h7F, r); chk("R10 unmapped read", r, 8'h00);

        // R7 one-second tick
        wr_reg(8'h52, 8'h40);
        tick_1s = 1'b1; step(); tick_1s = 1'b0;
        chk("R7 tick drives pin", {7'd0, irq_n}, 8'h00);
        rd_reg(8'h42, r); chk("R7 tick latched", r, 8'h40);
        rd_reg(8'h42, r); chk("R7 tick cleared", r, 8'h00);
        tick_1s = 1'b1; step(); tick_1s = 1'b0;
        bus_addr = 8'h42; bus_rd = 1'b1; tick_1s = 1'b1;
        step();
        bus_rd = 1'b0; tick_1s = 1'b0;
        chk("R7 read with tick", bus_rdata, 8'h40);
        rd_reg(8'h42, r); chk("R7 tick kept", r, 8'h40);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule